// File: doc/BRIEF.md
# Register/Memory Poll-Wait Unit

The unit carries out one poll-until-condition command at a time. A start strobe hands it a command: an operation select, an address-space select, a compare function code, the address to poll, a request address, a reference value, a mask and a control word. The unit then reads the poll address through a request/response read port. It ANDs each returned word with the mask and compares the result with the reference. When the condition holds, it finishes. When the condition fails, it waits a programmed number of clock cycles and reads again. This repeats until the retry budget is spent.

In write-then-wait mode, the unit first writes the reference value to the request address and only then starts polling. All requests, the write included, carry the space select bit, which picks register space (0) or memory space (1). On completion the unit gives a one-cycle `done` pulse. When the budget ran out without a match, `timeout` is raised in that same cycle.

The controller has five states:
- IDLE: waits for start.
- WRITE: holds the write request until it is accepted.
- READ: holds the read request until it is accepted.
- WAIT: waits for the read response.
- GAP: counts the poll interval.

The transitions are:
- IDLE→WRITE on start in write-then-wait mode.
- IDLE→READ on start in plain mode.
- WRITE→READ on write accept.
- READ→WAIT on read accept.
- WAIT→IDLE on a match or on an exhausted budget.
- WAIT→READ on a mismatch with a zero interval.
- WAIT→GAP on a mismatch with a non-zero interval.
- GAP→READ when the interval count runs out.

Top module: `pollwait_unit`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `req_valid` are all low.
- R2: A start is taken only while `busy` is low, and the command fields are captured at that edge. A start, or any change of the command inputs, while `busy` is high has no effect on the running command.
- R3: With `cmd_op`=1 (write-then-wait), exactly one write request (`req_write`=1) is made before the first read. It goes to `cmd_req_addr`, carries `cmd_ref` as data and uses `cmd_space`. With `cmd_op`=0, no write is made.
- R4: Every read request goes to `cmd_poll_addr` with `req_space` equal to `cmd_space`. A request stays asserted with stable address and direction until `req_ready` is high.
- R5: The function codes act on (rsp_data & mask) against the reference, unsigned: 0 always, 1 less than, 2 less or equal, 3 equal, 4 not equal, 5 greater or equal, 6 greater than. Code 7 never matches.
- R6: Function code 0 completes after the first read response, whatever the data.
- R7: `cmd_ctrl[31:16]` is the retry count N and `cmd_ctrl[15:0]` is the poll interval. At most N+1 reads are made.
- R8: After a failing response seen in cycle c, the next read request is first presented in cycle c+interval+1.
- R9: On a match, `done` is high for exactly one cycle, the cycle after the matching response, with `timeout` low and `busy` already low.
- R10: When the last permitted read fails, `done` and `timeout` are high together for one cycle, the cycle after that response, and the unit returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a new command |
| cmd_op | input | 1 | 0 plain wait, 1 write-then-wait |
| cmd_space | input | 1 | 0 register space, 1 memory space |
| cmd_func | input | 3 | Compare function code |
| cmd_poll_addr | input | ADDR_W | Address that is polled |
| cmd_req_addr | input | ADDR_W | Address written in write-then-wait mode |
| cmd_ref | input | DATA_W | Reference value (also the write data) |
| cmd_mask | input | DATA_W | Mask applied to read data |
| cmd_ctrl | input | RETRY_W+IVL_W | Retry count (upper) and poll interval (lower) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_space | output | 1 | Space select of the request |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | DATA_W | Read response data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Completion without a match |

## Verification
The hardest situation to reach is a poll loop that stalls on a random `req_ready` and response latency while the interval counter and the retry budget run down together. On top of that, a second start with altered command inputs can arrive mid-run. The bench reaches it by scripting the sequence of read values per command, so that the first match lands on a chosen attempt or never. The interval spacing is measured from each response to the next read request. In a directed run, the bench pulses start with a corrupted poll address during a long interval, so that any capture of the new fields shows up as a read to the wrong address.

// File: rtl/pollwait_pkg.sv
package pollwait_pkg;

    typedef enum logic [2:0] {
        PW_IDLE  = 3'd0,
        PW_WRITE = 3'd1,
        PW_READ  = 3'd2,
        PW_WAIT  = 3'd3,
        PW_GAP   = 3'd4
    } pw_state_e;

    typedef enum logic [2:0] {
        FN_ALWAYS = 3'd0,
        FN_LT     = 3'd1,
        FN_LE     = 3'd2,
        FN_EQ     = 3'd3,
        FN_NE     = 3'd4,
        FN_GE     = 3'd5,
        FN_GT     = 3'd6,
        FN_NEVER  = 3'd7
    } pw_func_e;

    localparam logic OP_PLAIN      = 1'b0;
    localparam logic OP_WRITE_WAIT = 1'b1;

endpackage

// File: rtl/pw_compare.sv
module pw_compare
    import pollwait_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        func,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] refv,
    output logic              hit
);
    logic [DATA_W-1:0] masked;

    always_comb begin
        masked = value & mask;
        unique case (pw_func_e'(func))
            FN_ALWAYS: hit = 1'b1;
            FN_LT:     hit = (masked <  refv);
            FN_LE:     hit = (masked <= refv);
            FN_EQ:     hit = (masked == refv);
            FN_NE:     hit = (masked != refv);
            FN_GE:     hit = (masked >= refv);
            FN_GT:     hit = (masked >  refv);
            FN_NEVER:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pw_down_counter.sv
module pw_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pollwait_unit.sv
module pollwait_unit
    import pollwait_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int RETRY_W = 16,
    parameter int IVL_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cmd_op,
    input  logic                     cmd_space,
    input  logic [2:0]               cmd_func,
    input  logic [ADDR_W-1:0]        cmd_poll_addr,
    input  logic [ADDR_W-1:0]        cmd_req_addr,
    input  logic [DATA_W-1:0]        cmd_ref,
    input  logic [DATA_W-1:0]        cmd_mask,
    input  logic [RETRY_W+IVL_W-1:0] cmd_ctrl,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic                     req_write,
    output logic                     req_space,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [DATA_W-1:0]        req_wdata,
    input  logic                     rsp_valid,
    input  logic [DATA_W-1:0]        rsp_data,
    output logic                     busy,
    output logic                     done,
    output logic                     timeout
);
    localparam int CTRL_W = RETRY_W + IVL_W;
    localparam logic [IVL_W-1:0] IVL_ONE = IVL_W'(1);

    pw_state_e state_q, state_d;

    // captured command
    logic              op_q;
    logic              space_q;
    logic [2:0]        func_q;
    logic [ADDR_W-1:0] poll_addr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] mask_q;
    logic [IVL_W-1:0]  ivl_q;

    logic accept, eval, hit, retry_zero, ivl_zero;
    logic retry_step, finish, give_up;
    logic [RETRY_W-1:0] retry_cnt;
    logic [IVL_W-1:0]   ivl_cnt;

    assign accept     = (state_q == PW_IDLE) && start;
    assign eval       = (state_q == PW_WAIT) && rsp_valid;
    assign finish     = eval && (hit || retry_zero);
    assign give_up    = eval && !hit && retry_zero;
    assign retry_step = eval && !hit && !retry_zero;

    pw_compare #(.DATA_W(DATA_W)) u_cmp (
        .func  (func_q),
        .value (rsp_data),
        .mask  (mask_q),
        .refv  (ref_q),
        .hit   (hit)
    );

    pw_down_counter #(.W(RETRY_W)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_ctrl[CTRL_W-1:IVL_W]),
        .dec      (retry_step),
        .cnt      (retry_cnt),
        .zero     (retry_zero)
    );

    pw_down_counter #(.W(IVL_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (retry_step),
        .load_val (ivl_q - IVL_ONE),
        .dec      (state_q == PW_GAP),
        .cnt      (ivl_cnt),
        .zero     (ivl_zero)
    );

    // command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_PLAIN;
            space_q     <= 1'b0;
            func_q      <= '0;
            poll_addr_q <= '0;
            req_addr_q  <= '0;
            ref_q       <= '0;
            mask_q      <= '0;
            ivl_q       <= '0;
        end else if (accept) begin
            op_q        <= cmd_op;
            space_q     <= cmd_space;
            func_q      <= cmd_func;
            poll_addr_q <= cmd_poll_addr;
            req_addr_q  <= cmd_req_addr;
            ref_q       <= cmd_ref;
            mask_q      <= cmd_mask;
            ivl_q       <= cmd_ctrl[IVL_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                if (start) state_d = (cmd_op == OP_WRITE_WAIT) ? PW_WRITE : PW_READ;
            end
            PW_WRITE: begin
                if (req_ready) state_d = PW_READ;
            end
            PW_READ: begin
                if (req_ready) state_d = PW_WAIT;
            end
            PW_WAIT: begin
                if (rsp_valid) begin
                    if (hit || retry_zero)  state_d = PW_IDLE;
                    else if (ivl_q == '0)   state_d = PW_READ;
                    else                    state_d = PW_GAP;
                end
            end
            PW_GAP: begin
                if (ivl_zero) state_d = PW_READ;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    // registered completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= finish;
            timeout <= give_up;
        end
    end

    // request port
    assign req_valid = (state_q == PW_WRITE) || (state_q == PW_READ);
    assign req_write = (state_q == PW_WRITE);
    assign req_space = space_q;
    assign req_addr  = (state_q == PW_WRITE) ? req_addr_q : poll_addr_q;
    assign req_wdata = ref_q;
    assign busy      = (state_q != PW_IDLE);

endmodule

// File: rtl/pollwait_unit_chk.sv
module pollwait_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid)); // R9

    AST_TIMEOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done); // R10
endmodule

bind pollwait_unit pollwait_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/pollwait_unit_test.sv
`timescale 1ns/1ps
module pollwait_unit_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmd_op = 1'b0;
    logic          cmd_space = 1'b0;
    logic [2:0]    cmd_func = '0;
    logic [AW-1:0] cmd_poll_addr = '0;
    logic [AW-1:0] cmd_req_addr = '0;
    logic [DW-1:0] cmd_ref = '0;
    logic [DW-1:0] cmd_mask = '0;
    logic [31:0]   cmd_ctrl = '0;
    logic          req_valid, req_write, req_space;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          busy, done, timeout;

    always #2 clk = ~clk; // 250 MHz

    pollwait_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_space(cmd_space),
        .cmd_func(cmd_func), .cmd_poll_addr(cmd_poll_addr), .cmd_req_addr(cmd_req_addr),
        .cmd_ref(cmd_ref), .cmd_mask(cmd_mask), .cmd_ctrl(cmd_ctrl),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .done(done), .timeout(timeout)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // expectations for the running command
    logic [DW-1:0] vals [8];
    logic [AW-1:0] exp_poll, exp_req;
    logic [DW-1:0] exp_ref;
    logic          exp_space;
    int            exp_ivl;

    // responder bookkeeping
    int            cyc = 0;
    int            rd_count = 0, wr_count = 0, done_cnt = 0, to_cnt = 0;
    int            pend_cnt = 0, resp_idx = 0, rsp_cyc = 0;
    bit            rd_seen = 0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          wr_space;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input int f, input logic [31:0] v, input logic [31:0] m,
                                     input logic [31:0] r);
        logic [31:0] x;
        x = v & m;
        case (f)
            0: return 1'b1;
            1: return x <  r;
            2: return x <= r;
            3: return x == r;
            4: return x != r;
            5: return x >= r;
            6: return x >  r;
            default: return 1'b0;
        endcase
    endfunction

    // memory-side responder
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (done) begin
                done_cnt++;
                if (timeout) to_cnt++;
                chk(cyc == rsp_cyc + 1, "R9 done cycle", 64'(cyc), 64'(rsp_cyc + 1));
            end
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = vals[(resp_idx > 7) ? 7 : resp_idx];
                    rsp_cyc   = cyc;
                end
            end
            req_ready = ($urandom_range(0, 3) != 0);
            if (req_valid && !req_write && !rd_seen) begin
                rd_seen = 1;
                if (rd_count > 0)
                    chk(cyc - rsp_cyc == exp_ivl + 1, "R8 interval", 64'(cyc - rsp_cyc), 64'(exp_ivl + 1));
            end
            if (req_valid && req_ready) begin
                if (req_write) begin
                    wr_count++;
                    wr_addr  = req_addr;
                    wr_data  = req_wdata;
                    wr_space = req_space;
                    chk(rd_count == 0, "R3 write before read", 64'(rd_count), 64'd0);
                end else begin
                    chk(req_addr == exp_poll && req_space == exp_space, "R4 read addr/space",
                        {31'd0, req_space, req_addr}, {31'd0, exp_space, exp_poll});
                    resp_idx = rd_count;
                    rd_count++;
                    rd_seen  = 0;
                    pend_cnt = 1 + $urandom_range(0, 2);
                end
            end
        end
    end

    task automatic run_cmd(input bit op, input bit sp, input int f, input logic [31:0] poll,
                           input logic [31:0] reqa, input logic [31:0] rf, input logic [31:0] m,
                           input int retry, input int ivl, input bit disturb, input string tag);
        int exp_reads;
        bit exp_to;
        int waitc;
        exp_poll = poll; exp_req = reqa; exp_ref = rf; exp_space = sp; exp_ivl = ivl;
        exp_to = 1; exp_reads = retry + 1;
        for (int k = 0; k <= retry; k++) begin
            if (model_hit(f, vals[(k > 7) ? 7 : k], m, rf)) begin
                exp_reads = k + 1; exp_to = 0; break;
            end
        end
        @(negedge clk); #1;
        rd_count = 0; wr_count = 0; done_cnt = 0; to_cnt = 0; rd_seen = 0;
        cmd_op = op; cmd_space = sp; cmd_func = 3'(f); cmd_poll_addr = poll; cmd_req_addr = reqa;
        cmd_ref = rf; cmd_mask = m; cmd_ctrl = {16'(retry), 16'(ivl)};
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            @(negedge clk); #1;
            chk(busy == 1'b1, "R2 busy during run", 64'(busy), 64'd1);
            cmd_poll_addr = ~poll; cmd_op = ~op; cmd_func = 3'd7; cmd_ctrl = 32'h0;
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        waitc = 0;
        while (done_cnt == 0 && waitc < 2000) begin
            @(negedge clk); #1;
            waitc++;
        end
        chk(busy == 1'b0, {tag, " R9 idle at done"}, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(done_cnt == 1, {tag, " R9 one done"}, 64'(done_cnt), 64'd1);
        chk(to_cnt == int'(exp_to), {tag, " R10 timeout"}, 64'(to_cnt), 64'(exp_to));
        chk(rd_count == exp_reads, {tag, " R7 read count"}, 64'(rd_count), 64'(exp_reads));
        chk(wr_count == int'(op), {tag, " R3 write count"}, 64'(wr_count), 64'(op));
        if (op)
            chk(wr_addr == reqa && wr_data == rf && wr_space == sp, {tag, " R3 write fields"},
                {wr_addr, wr_data}, {reqa, rf});
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) vals[i] = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(!busy && !done && !timeout && !req_valid, "R1 reset state",
            {busy, done, timeout, req_valid}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !req_valid, "R1 idle after reset", {busy, req_valid}, 2'b0);

        // R3 R5: write-then-wait, equality matches on third read
        vals[0] = 1; vals[1] = 2; vals[2] = 5; vals[3] = 5;
        run_cmd(1, 1, 3, 32'h100, 32'h200, 32'd5, 32'hFFFF_FFFF, 4, 2, 0, "eq3");
        // R6: function 0 ends after first read
        vals[0] = 32'hDEAD; vals[1] = 0;
        run_cmd(0, 0, 0, 32'h140, 32'h0, 32'd7, 32'hFFFF_FFFF, 5, 1, 0, "always");
        // R5 R10: code 7 never matches, exhausts budget
        run_cmd(0, 1, 7, 32'h180, 32'h0, 32'd0, 32'hFFFF_FFFF, 2, 0, 0, "never");
        // R10: zero retries, single failing read
        vals[0] = 3;
        run_cmd(1, 0, 3, 32'h1C0, 32'h44, 32'd9, 32'hFFFF_FFFF, 0, 3, 0, "retry0");
        // R2 R8: start during run with corrupted fields, long interval
        vals[0] = 1; vals[1] = 1; vals[2] = 9;
        run_cmd(0, 1, 6, 32'h240, 32'h0, 32'd4, 32'hFFFF_FFFF, 2, 20, 1, "disturb");
        // R5: mask isolates a byte
        vals[0] = 32'h12AB;
        run_cmd(0, 0, 3, 32'h280, 32'h0, 32'h1200, 32'hFF00, 1, 0, 0, "mask");

        // random commands
        for (int n = 0; n < 40; n++) begin
            logic [31:0] rf, m;
            int f, rt, iv;
            rf = $urandom_range(2, 200);
            m  = ($urandom_range(0, 3) == 0) ? 32'h0000_00F0 : 32'hFFFF_FFFF;
            f  = $urandom_range(0, 7);
            rt = $urandom_range(0, 5);
            iv = $urandom_range(0, 4);
            for (int i = 0; i < 8; i++) begin
                case ($urandom_range(0, 3))
                    0: vals[i] = rf;
                    1: vals[i] = rf + 1;
                    2: vals[i] = rf - 1;
                    default: vals[i] = $urandom;
                endcase
            end
            run_cmd(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), f, $urandom, $urandom,
                    rf, m, rt, iv, 0, "rand");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule